// File: doc/BRIEF.md
# Banked Register File Address Unit

This unit turns each data-memory request of a small microcontroller core into a 9-bit physical register-file address. The register file spans four banks of 128 locations each. The unit supports two kinds of access. A direct access takes the 7-bit file field of the instruction and prefixes it with the two bank-select bits held in the status byte. An indirect access is requested by naming file slot 00h. That slot has no storage of its own. It stands for the location held in an 8-bit pointer register, extended by a ninth bit from the status byte.

A small set of special-function slots appears at one physical location no matter which bank is selected. Whenever the low seven bits of the resolved address match one of these slots, the unit folds the address into bank 0 and raises a mirror flag. It does this for both kinds of access. The unit registers its result once, so the storage array behind it sees a clean address and strobe set one cycle after the request. An indirect access whose pointer names the indirect slot itself cannot reach storage. A read of that kind is flagged so that the consumer returns zero, and a write of that kind is dropped.

Top module: `bank_addr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `phys_addr` = 0 and `mem_rd`, `mem_wr`, `rd_zero`, `mirror_hit`, `via_ptr` all 0, whatever the request inputs are.
- R2: A request with `file_sel` ≠ 00h and a non-mirrored slot yields `phys_addr` = {`status_q[6:5]`, `file_sel`} and `via_ptr` = 0. Bit 6 is the upper bank bit and bit 5 is the lower one.
- R3: A request with `file_sel` = 00h is indirect. It yields `phys_addr` = {`status_q[7]`, `fsr_q`} (unless R5 folds it) and `via_ptr` = 1.
- R4: `status_q[7]` has no effect on a direct access, and `status_q[6:5]` have no effect on an indirect access.
- R5: When the low 7 bits of the resolved address are 00h, 02h, 03h, 04h, 0Ah or 0Bh, `phys_addr` = {2'b00, low 7 bits} and `mirror_hit` = 1. Otherwise `mirror_hit` = 0. This applies to both direct and indirect accesses.
- R6: An indirect access whose resolved low 7 bits are 00h gives `mem_rd` = 0 and `mem_wr` = 0. It gives `rd_zero` = 1 when it is a read. `mem_rd` and `rd_zero` are never high together.
- R7: All outputs change one clock after the request is sampled.
- R8: A cycle with neither `rd_req` nor `wr_req` gives `mem_rd`, `mem_wr` and `rd_zero` = 0 in the next cycle. `phys_addr`, `mirror_hit` and `via_ptr` keep their previous values.
- R9: `mem_rd` follows `rd_req` and `mem_wr` follows `wr_req`, each independently, so both may be high together for a read-modify-write. R6 is the only exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| file_sel | input | 7 | File field of the current instruction |
| status_q | input | 8 | Status byte; bit 7 is the pointer bank bit, bits 6:5 are the direct bank bits |
| fsr_q | input | 8 | Pointer register value |
| rd_req | input | 1 | Read strobe for this access |
| wr_req | input | 1 | Write strobe for this access |
| phys_addr | output | 9 | Resolved physical register-file address |
| mem_rd | output | 1 | Read enable toward storage |
| mem_wr | output | 1 | Write enable toward storage |
| rd_zero | output | 1 | Read through a self-referencing pointer; the consumer returns zero |
| mirror_hit | output | 1 | Address was folded to a bank-0 mirrored slot |
| via_ptr | output | 1 | Access was resolved through the pointer |

## Verification
The same file fields are sent under all four bank settings. This separates a correct bank prefix from a swapped or dropped bank bit. The pointer bank bit is also set during direct accesses, and the direct bank bits during indirect ones, to expose any cross-wiring between the two paths. Each mirrored slot is reached from a non-zero bank, along with its non-mirrored neighbours and pointer values whose upper bits are set. This distinguishes folding by the low seven bits from folding by the full address. Self-pointing reads, writes and combined accesses, plus idle cycles and a long random run, check strobe suppression and address holding against a behavioural model on every clock.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;

    localparam int FILE_W    = 7;
    localparam int BANK_W    = 2;
    localparam int ADDR_W    = FILE_W + BANK_W;
    localparam int PTR_W     = ADDR_W - 1;
    localparam int STAT_W    = 8;
    localparam int RP_LO     = 5;
    localparam int IRP_BIT   = 7;
    localparam int MIR_SPAN  = 16;
    localparam int MIR_IDX_W = $clog2(MIR_SPAN);

    typedef logic [ADDR_W-1:0] faddr_t;
    typedef logic [FILE_W-1:0] slot_t;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_DIRECT   = 2'd1,
        MODE_INDIRECT = 2'd2
    } amode_e;

    typedef struct packed {
        faddr_t addr;
        logic   mirror;
        logic   indirect;
        logic   self_ptr;
    } route_t;

    function automatic slot_t low_slot(input faddr_t a);
        return a[FILE_W-1:0];
    endfunction

    function automatic logic slot_in_span(input slot_t s);
        return (s >> MIR_IDX_W) == '0;
    endfunction

endpackage

// File: rtl/bank_direct_path.sv
module bank_direct_path
    import bank_addr_pkg::*;
(
    input  logic [FILE_W-1:0] file_sel,
    input  logic [BANK_W-1:0] bank_bits,
    output faddr_t            addr
);
    assign addr = {bank_bits, file_sel};
endmodule

// File: rtl/bank_indirect_path.sv
module bank_indirect_path
    import bank_addr_pkg::*;
(
    input  logic             ptr_bank,
    input  logic [PTR_W-1:0] ptr_val,
    output faddr_t           addr
);
    assign addr = {ptr_bank, ptr_val};
endmodule

// File: rtl/bank_mirror_fold.sv
module bank_mirror_fold
    import bank_addr_pkg::*;
#(
    parameter logic [MIR_SPAN-1:0] MIRROR_MASK = 16'h0C1D
)(
    input  faddr_t eff_addr,
    output faddr_t fold_addr,
    output logic   hit
);
    slot_t               slot;
    logic [MIR_SPAN-1:0] match;

    assign slot = low_slot(eff_addr);

    generate
        for (genvar gi = 0; gi < MIR_SPAN; gi++) begin : g_slot
            if (MIRROR_MASK[gi]) begin : g_on
                assign match[gi] = slot_in_span(slot) &&
                                   (slot[MIR_IDX_W-1:0] == MIR_IDX_W'(gi));
            end else begin : g_off
                assign match[gi] = 1'b0;
            end
        end
    endgenerate

    assign hit       = |match;
    assign fold_addr = hit ? {{BANK_W{1'b0}}, slot} : eff_addr;
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
    import bank_addr_pkg::*;
#(
    parameter logic [MIR_SPAN-1:0] MIRROR_MASK = 16'h0C1D,
    parameter int                  PTR_SLOT    = 0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [FILE_W-1:0] file_sel,
    input  logic [STAT_W-1:0] status_q,
    input  logic [PTR_W-1:0]  fsr_q,
    input  logic              rd_req,
    input  logic              wr_req,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              rd_zero,
    output logic              mirror_hit,
    output logic              via_ptr
);
    localparam slot_t PTR_SLOT_V = slot_t'(PTR_SLOT);

    logic   unused_stat;
    amode_e mode;
    faddr_t dir_addr;
    faddr_t ind_addr;
    faddr_t eff_addr;
    faddr_t fold_addr;
    logic   fold_hit;
    route_t route;

    assign unused_stat = ^status_q[RP_LO-1:0];

    always_comb begin
        if (!(rd_req || wr_req))          mode = MODE_IDLE;
        else if (file_sel == PTR_SLOT_V)  mode = MODE_INDIRECT;
        else                              mode = MODE_DIRECT;
    end

    bank_direct_path u_dir (
        .file_sel  (file_sel),
        .bank_bits (status_q[RP_LO +: BANK_W]),
        .addr      (dir_addr)
    );

    bank_indirect_path u_ind (
        .ptr_bank (status_q[IRP_BIT]),
        .ptr_val  (fsr_q),
        .addr     (ind_addr)
    );

    assign eff_addr = (mode == MODE_INDIRECT) ? ind_addr : dir_addr;

    bank_mirror_fold #(.MIRROR_MASK(MIRROR_MASK)) u_fold (
        .eff_addr  (eff_addr),
        .fold_addr (fold_addr),
        .hit       (fold_hit)
    );

    always_comb begin
        route.addr     = fold_addr;
        route.mirror   = fold_hit;
        route.indirect = (mode == MODE_INDIRECT);
        route.self_ptr = (mode == MODE_INDIRECT) &&
                         (low_slot(eff_addr) == PTR_SLOT_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phys_addr  <= '0;
            mem_rd     <= 1'b0;
            mem_wr     <= 1'b0;
            rd_zero    <= 1'b0;
            mirror_hit <= 1'b0;
            via_ptr    <= 1'b0;
        end else begin
            mem_rd  <= rd_req && !route.self_ptr;
            mem_wr  <= wr_req && !route.self_ptr;
            rd_zero <= rd_req &&  route.self_ptr;
            if (mode != MODE_IDLE) begin
                phys_addr  <= route.addr;
                mirror_hit <= route.mirror;
                via_ptr    <= route.indirect;
            end
        end
    end
endmodule

// File: rtl/bank_addr_unit_chk.sv
module bank_addr_unit_chk
    import bank_addr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [FILE_W-1:0] file_sel,
    input logic              rd_req,
    input logic              wr_req,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              rd_zero,
    input logic              mirror_hit,
    input logic              via_ptr
);
    logic req;
    assign req = rd_req || wr_req;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (phys_addr == '0 && !mem_rd && !mem_wr && !rd_zero && !mirror_hit && !via_ptr));

    assert_direct_low_R2: assert property (@(posedge clk) disable iff (rst)
        (req && file_sel != '0) |=> (!via_ptr && phys_addr[FILE_W-1:0] == $past(file_sel)));

    assert_ptr_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (req && file_sel == '0) |=> via_ptr);

    assert_mirror_bank0_R5: assert property (@(posedge clk) disable iff (rst)
        mirror_hit |-> (phys_addr[ADDR_W-1:FILE_W] == '0));

    assert_rd_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && rd_zero));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(phys_addr) && $stable(mirror_hit) && $stable(via_ptr)
                  && !mem_rd && !mem_wr && !rd_zero));

    assert_rd_follow_R9: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (mem_rd || rd_zero));

    assert_wr_source_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> !mem_wr);
endmodule

bind bank_addr_unit bank_addr_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .file_sel   (file_sel),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .phys_addr  (phys_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .rd_zero    (rd_zero),
    .mirror_hit (mirror_hit),
    .via_ptr    (via_ptr)
);

// File: tb/sim_bank_addr_unit.sv
module sim_bank_addr_unit;
    localparam time TCK = 20ns;

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] file_sel;
    logic [7:0] status_q;
    logic [7:0] fsr_q;
    logic       rd_req, wr_req;
    logic [8:0] phys_addr;
    logic       mem_rd, mem_wr, rd_zero, mirror_hit, via_ptr;

    always #(TCK/2) clk = ~clk;

    bank_addr_unit u0 (
        .clk(clk), .rst(rst), .file_sel(file_sel), .status_q(status_q),
        .fsr_q(fsr_q), .rd_req(rd_req), .wr_req(wr_req),
        .phys_addr(phys_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .rd_zero(rd_zero), .mirror_hit(mirror_hit), .via_ptr(via_ptr)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int e_addr = 0, e_mir = 0, e_via = 0, e_rd = 0, e_wr = 0, e_zero = 0;

    function automatic bit mirrored(int low);
        return low == 0 || low == 2 || low == 3 || low == 4 || low == 10 || low == 11;
    endfunction

    task automatic model();
        int eff, low;
        bit ind, nul;
        if (!(rd_req || wr_req)) begin
            e_rd = 0; e_wr = 0; e_zero = 0;
        end else begin
            ind = (file_sel == 0);
            if (ind) eff = int'(status_q[7]) * 256 + int'(fsr_q);
            else     eff = ((int'(status_q) / 32) % 4) * 128 + int'(file_sel);
            low    = eff % 128;
            nul    = ind && (low == 0);
            e_via  = ind;
            e_mir  = mirrored(low);
            e_addr = e_mir ? low : eff;
            e_rd   = rd_req && !nul;
            e_wr   = wr_req && !nul;
            e_zero = rd_req && nul;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(phys_addr) != e_addr || int'(mem_rd) != e_rd || int'(mem_wr) != e_wr ||
            int'(rd_zero) != e_zero || int'(mirror_hit) != e_mir || int'(via_ptr) != e_via) begin
            errors++;
            $display("FAIL %s: got addr=%03h rd=%0d wr=%0d zero=%0d mir=%0d ptr=%0d, expected addr=%03h rd=%0d wr=%0d zero=%0d mir=%0d ptr=%0d",
                     tag, phys_addr, mem_rd, mem_wr, rd_zero, mirror_hit, via_ptr,
                     e_addr, e_rd, e_wr, e_zero, e_mir, e_via);
        end
    endtask

    task automatic step(input logic [6:0] f, input logic [7:0] s, input logic [7:0] p,
                        input logic r, input logic w, input string tag);
        file_sel = f; status_q = s; fsr_q = p; rd_req = r; wr_req = w;
        model();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        rst = 1'b1; file_sel = 7'h25; status_q = 8'hE0; fsr_q = 8'h33;
        rd_req = 1'b1; wr_req = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1 reset clears outputs");
        rst = 1'b0;

        step(7'h25, 8'h00, 8'h00, 1, 0, "R2 bank0 direct");
        step(7'h25, 8'h20, 8'h00, 1, 0, "R2 bank1 direct");
        step(7'h25, 8'h40, 8'h00, 0, 1, "R2 bank2 direct");
        step(7'h25, 8'h60, 8'h00, 1, 0, "R2 R7 bank3 direct");
        step(7'h7F, 8'h60, 8'h00, 1, 0, "R2 top address");
        step(7'h30, 8'hA0, 8'h00, 1, 0, "R4 pointer bank bit ignored direct");
        step(7'h00, 8'h00, 8'h45, 1, 0, "R3 indirect low");
        step(7'h00, 8'h80, 8'h45, 1, 0, "R3 indirect high");
        step(7'h00, 8'h60, 8'h21, 0, 1, "R4 bank bits ignored indirect");
        step(7'h00, 8'hE0, 8'h21, 1, 0, "R3 R4 all bank bits set indirect");
        step(7'h03, 8'h60, 8'h00, 1, 0, "R5 mirror slot 03 bank3");
        step(7'h0B, 8'h40, 8'h00, 1, 0, "R5 mirror slot 0B bank2");
        step(7'h0A, 8'h20, 8'h00, 0, 1, "R5 mirror slot 0A bank1");
        step(7'h02, 8'h20, 8'h00, 1, 0, "R5 mirror slot 02 bank1");
        step(7'h01, 8'h20, 8'h00, 1, 0, "R5 non-mirror 01");
        step(7'h05, 8'h60, 8'h00, 1, 0, "R5 non-mirror 05");
        step(7'h0C, 8'h40, 8'h00, 1, 0, "R5 non-mirror 0C");
        step(7'h00, 8'h80, 8'h84, 1, 0, "R5 indirect mirror fold");
        step(7'h00, 8'h00, 8'h8A, 0, 1, "R5 indirect mirror fold 0A");
        step(7'h00, 8'h00, 8'h00, 1, 0, "R6 self pointer read");
        step(7'h00, 8'h80, 8'h80, 0, 1, "R6 self pointer write");
        step(7'h00, 8'h80, 8'h00, 1, 1, "R6 self pointer read-write");
        step(7'h44, 8'h60, 8'h12, 0, 0, "R8 idle hold");
        step(7'h00, 8'h00, 8'h77, 0, 0, "R8 idle hold again");
        step(7'h50, 8'h40, 8'h00, 1, 1, "R9 read-modify-write");
        step(7'h00, 8'h00, 8'h5A, 1, 1, "R9 indirect read-modify-write");

        for (int i = 0; i < 400; i++) begin
            logic [6:0] f;
            logic [7:0] s, p;
            f = 7'($urandom);
            if (($urandom % 4) == 0) f = 7'h00;
            if (($urandom % 4) == 0) f = 7'($urandom % 16);
            s = 8'($urandom);
            p = 8'($urandom);
            if (($urandom % 8) == 0) p = {p[7], 7'h00};
            step(f, s, p, 1'($urandom), 1'($urandom), "R2 R3 R5 R6 R9 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule